// File: doc/BRIEF.md
# Power Bus Message Decoder

This block sits at the receiving end of a power-management message bus. It owns a table of 28 power resources: voltage providers, reset and control lines, and one main reference. Every resource keeps a 4-bit state. Each resource also carries settings that are wired in from outside the block: which processor groups it belongs to, two type fields used for filtering, and two replacement states, one for an incoming off command and one for an incoming sleep command.

Each 16-bit message arrives with a one-cycle valid strobe. It is one of two kinds. A singular message names one resource by number. A broadcast message reaches every resource whose class, type and secondary type pass the message's filters. In both cases a resource accepts the command only if it shares at least one processor group with the message. The state written is the commanded state, unless the command is off or sleep and the resource substitutes its own value. The table is registered, so a message accepted at one clock edge shows on the outputs straight after that edge. Next to each state the block drives an enable flag, which is high while the resource is active or in warm reset.

Top module: `pwrmsg_decoder`

## Requirements
- R1: After reset every resource state is 0x0 (off) and every enable output is low.
- R2: Singular message layout: bit 12 = 0, processor group [15:13], resource ID [11:4], state [3:0]. Resource N (1 to 28) takes the state at the clock edge that samples msg_valid, and every other resource keeps its state. Resource N uses bit slice [(N-1)*w +: w] of every per-resource vector, where w is the field width (3, 3, 2, 4 or 4), and of res_state (w = 4). res_enable uses bit N-1.
- R3: A singular message whose ID is 0 or greater than 28 changes no state.
- R4: A resource is updated only when its processor-group mask ANDed with message bits [15:13] is nonzero. The group bits are P1 = 1, P2 = 2, P3 = 4. A message group of 0 therefore changes nothing.
- R5: Broadcast message layout: bit 12 = 1, processor group [15:13], resource-class mask [11:9], secondary type [8:7], type [6:4], state [3:0]. The class bit of a resource is 1 for IDs 1 to 21, 2 for IDs 22 to 27 and 4 for ID 28. A resource accepts the broadcast when four conditions hold together: its class bit ANDed with [11:9] is nonzero, the type field equals its configured type or is 7, the secondary type equals its configured secondary type, and R4 holds. All resources that accept are updated in the same cycle.
- R6: A commanded state of 0x0 is stored as the resource's off-replacement value, and 0x8 as its sleep-replacement value. Every other commanded state value (0xE active, 0xF warm reset, and the rest) is stored unchanged.
- R7: res_enable bit N-1 is high exactly when resource N holds state 0xE or 0xF.
- R8: While msg_valid is low, no state changes, whatever msg_data carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| msg_valid | input | 1 | msg_data holds a message this cycle |
| msg_data | input | 16 | Power bus message |
| cfg_devgrp | input | 84 | Per-resource processor-group mask, 3 bits each |
| cfg_kind | input | 84 | Per-resource type, 3 bits each |
| cfg_kind2 | input | 56 | Per-resource secondary type, 2 bits each |
| cfg_remap_off | input | 112 | Per-resource state stored on an off command, 4 bits each |
| cfg_remap_sleep | input | 112 | Per-resource state stored on a sleep command, 4 bits each |
| res_state | output | 112 | Current state of each resource, 4 bits each |
| res_enable | output | 28 | Resource is active or in warm reset |

## Verification
The assertions assume that msg_valid and msg_data are stable around the rising edge. They also assume the configuration vectors do not change in the same cycle as a message whose replacement value is being checked. The bench drives every input on the falling edge. It changes the configuration only between messages, always with msg_valid low. It feeds random data on msg_data during idle cycles, so that R8 is exercised against real content. Random messages are biased toward valid IDs and toward the four named states, so that acceptance, remapping and rejection each occur often.

// File: rtl/pwrmsg_pkg.sv
package pwrmsg_pkg;

    localparam int MSG_W   = 16;
    localparam int GRP_W   = 3;
    localparam int KIND_W  = 3;
    localparam int KIND2_W = 2;
    localparam int ID_W    = 8;
    localparam int ST_W    = 4;

    localparam logic [ST_W-1:0]   ST_OFF    = 4'h0;
    localparam logic [ST_W-1:0]   ST_SLEEP  = 4'h8;
    localparam logic [ST_W-1:0]   ST_ACTIVE = 4'hE;
    localparam logic [ST_W-1:0]   ST_WRST   = 4'hF;
    localparam logic [KIND_W-1:0] KIND_ANY  = 3'd7;

    localparam logic [GRP_W-1:0] CLASS_PROV = 3'b001;
    localparam logic [GRP_W-1:0] CLASS_RC   = 3'b010;
    localparam logic [GRP_W-1:0] CLASS_REF  = 3'b100;

    // Fields of a message. id overlaps the class, secondary type and type fields
    typedef struct packed {
        logic [GRP_W-1:0]   devgrp;
        logic               bcast;
        logic [GRP_W-1:0]   rclass;
        logic [KIND2_W-1:0] kind2;
        logic [KIND_W-1:0]  kind;
        logic [ID_W-1:0]    id;
        logic [ST_W-1:0]    state;
    } pmsg_t;

    // Class bit of a resource, taken from its number
    function automatic logic [GRP_W-1:0] res_class(input int id, input int prov_last,
                                                   input int rc_last);
        if (id <= prov_last)
            return CLASS_PROV;
        else if (id <= rc_last)
            return CLASS_RC;
        else
            return CLASS_REF;
    endfunction

endpackage

// File: rtl/pwrmsg_parse.sv
module pwrmsg_parse
    import pwrmsg_pkg::*;
#(
    parameter int NUM_RES = 28
) (
    input  logic             valid,
    input  logic [MSG_W-1:0] data,
    output pmsg_t            fld,
    output logic             single_ok,
    output logic             bcast_ok
);

    localparam logic [ID_W-1:0] MAX_ID = ID_W'(NUM_RES);

    always_comb begin
        fld.devgrp = data[15:13];
        fld.bcast  = data[12];
        fld.rclass = data[11:9];
        fld.kind2  = data[8:7];
        fld.kind   = data[6:4];
        fld.id     = data[11:4];
        fld.state  = data[3:0];

        single_ok = valid && !fld.bcast && (fld.devgrp != '0)
                    && (fld.id != '0) && (fld.id <= MAX_ID);
        bcast_ok  = valid && fld.bcast && (fld.devgrp != '0)
                    && (fld.rclass != '0);
    end

endmodule

// File: rtl/pwrmsg_slot.sv
module pwrmsg_slot
    import pwrmsg_pkg::*;
#(
    parameter int RES_ID    = 1,
    parameter int PROV_LAST = 21,
    parameter int RC_LAST   = 27
) (
    input  pmsg_t              fld,
    input  logic               single_ok,
    input  logic               bcast_ok,
    input  logic [GRP_W-1:0]   cfg_devgrp,
    input  logic [KIND_W-1:0]  cfg_kind,
    input  logic [KIND2_W-1:0] cfg_kind2,
    input  logic [ST_W-1:0]    cfg_off,
    input  logic [ST_W-1:0]    cfg_sleep,
    output logic               hit,
    output logic [ST_W-1:0]    new_state
);

    localparam logic [GRP_W-1:0] MY_CLASS = res_class(RES_ID, PROV_LAST, RC_LAST);
    localparam logic [ID_W-1:0]  MY_ID    = ID_W'(RES_ID);

    logic grp_hit;
    logic single_hit;
    logic kind_hit;
    logic bcast_hit;

    always_comb begin
        grp_hit    = |(cfg_devgrp & fld.devgrp);
        single_hit = single_ok && (fld.id == MY_ID);
        kind_hit   = (fld.kind == KIND_ANY) || (fld.kind == cfg_kind);
        bcast_hit  = bcast_ok && (|(MY_CLASS & fld.rclass)) && kind_hit
                     && (fld.kind2 == cfg_kind2);
        hit        = grp_hit && (single_hit || bcast_hit);

        case (fld.state)
            ST_OFF:   new_state = cfg_off;
            ST_SLEEP: new_state = cfg_sleep;
            default:  new_state = fld.state;
        endcase
    end

endmodule

// File: rtl/pwrmsg_decoder.sv
module pwrmsg_decoder
    import pwrmsg_pkg::*;
#(
    parameter int NUM_RES   = 28,
    parameter int PROV_LAST = 21,
    parameter int RC_LAST   = 27
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      msg_valid,
    input  logic [MSG_W-1:0]          msg_data,
    input  logic [NUM_RES*GRP_W-1:0]  cfg_devgrp,
    input  logic [NUM_RES*KIND_W-1:0] cfg_kind,
    input  logic [NUM_RES*KIND2_W-1:0] cfg_kind2,
    input  logic [NUM_RES*ST_W-1:0]   cfg_remap_off,
    input  logic [NUM_RES*ST_W-1:0]   cfg_remap_sleep,
    output logic [NUM_RES*ST_W-1:0]   res_state,
    output logic [NUM_RES-1:0]        res_enable
);

    typedef struct packed {
        logic [NUM_RES-1:0][ST_W-1:0] state;
        logic [NUM_RES-1:0]           enable;
    } regs_t;

    regs_t r_d, r_q;

    pmsg_t                        fld;
    logic                         single_ok;
    logic                         bcast_ok;
    logic [NUM_RES-1:0]           hit;
    logic [NUM_RES-1:0][ST_W-1:0] upd;

    pwrmsg_parse #(
        .NUM_RES (NUM_RES)
    ) i_parse (
        .valid     (msg_valid),
        .data      (msg_data),
        .fld       (fld),
        .single_ok (single_ok),
        .bcast_ok  (bcast_ok)
    );

    for (genvar g = 0; g < NUM_RES; g++) begin : g_slot
        pwrmsg_slot #(
            .RES_ID    (g + 1),
            .PROV_LAST (PROV_LAST),
            .RC_LAST   (RC_LAST)
        ) i_slot (
            .fld        (fld),
            .single_ok  (single_ok),
            .bcast_ok   (bcast_ok),
            .cfg_devgrp (cfg_devgrp[g*GRP_W +: GRP_W]),
            .cfg_kind   (cfg_kind[g*KIND_W +: KIND_W]),
            .cfg_kind2  (cfg_kind2[g*KIND2_W +: KIND2_W]),
            .cfg_off    (cfg_remap_off[g*ST_W +: ST_W]),
            .cfg_sleep  (cfg_remap_sleep[g*ST_W +: ST_W]),
            .hit        (hit[g]),
            .new_state  (upd[g])
        );
    end

    always_comb begin
        r_d = r_q;
        for (int i = 0; i < NUM_RES; i++) begin
            if (hit[i])
                r_d.state[i] = upd[i];
            r_d.enable[i] = (r_d.state[i] == ST_ACTIVE) || (r_d.state[i] == ST_WRST);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    assign res_state  = r_q.state;
    assign res_enable = r_q.enable;

endmodule

// File: rtl/pwrmsg_decoder_chk.sv
module pwrmsg_decoder_chk
    import pwrmsg_pkg::*;
#(
    parameter int NUM_RES = 28
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      msg_valid,
    input logic [MSG_W-1:0]          msg_data,
    input logic [NUM_RES*GRP_W-1:0]  cfg_devgrp,
    input logic [NUM_RES*ST_W-1:0]   cfg_remap_off,
    input logic [NUM_RES*ST_W-1:0]   cfg_remap_sleep,
    input logic [NUM_RES*ST_W-1:0]   res_state
);

    localparam logic [ID_W-1:0] MAX_ID = ID_W'(NUM_RES);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_valid |=> $stable(res_state));

    assert_bad_id_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_data[12] && ((msg_data[11:4] == '0) || (msg_data[11:4] > MAX_ID)))
        |=> $stable(res_state));

    assert_no_group_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && (msg_data[15:13] == '0)) |=> $stable(res_state));

    for (genvar g = 0; g < NUM_RES; g++) begin : g_res
        localparam logic [ID_W-1:0] MY_ID = ID_W'(g + 1);

        assert_single_isolate_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (msg_valid && !msg_data[12] && (msg_data[11:4] != MY_ID))
            |=> $stable(res_state[g*ST_W +: ST_W]));

        assert_single_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (msg_valid && !msg_data[12] && (msg_data[11:4] == MY_ID)
             && ((cfg_devgrp[g*GRP_W +: GRP_W] & msg_data[15:13]) != '0)
             && (msg_data[3:0] == ST_ACTIVE))
            |=> (res_state[g*ST_W +: ST_W] == ST_ACTIVE));

        assert_remap_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (msg_valid && !msg_data[12] && (msg_data[11:4] == MY_ID)
             && ((cfg_devgrp[g*GRP_W +: GRP_W] & msg_data[15:13]) != '0)
             && (msg_data[3:0] == ST_OFF))
            |=> (res_state[g*ST_W +: ST_W] == $past(cfg_remap_off[g*ST_W +: ST_W])));

        assert_remap_sleep_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (msg_valid && !msg_data[12] && (msg_data[11:4] == MY_ID)
             && ((cfg_devgrp[g*GRP_W +: GRP_W] & msg_data[15:13]) != '0)
             && (msg_data[3:0] == ST_SLEEP))
            |=> (res_state[g*ST_W +: ST_W] == $past(cfg_remap_sleep[g*ST_W +: ST_W])));
    end

endmodule

bind pwrmsg_decoder pwrmsg_decoder_chk #(
    .NUM_RES (NUM_RES)
) i_pwrmsg_decoder_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .msg_valid       (msg_valid),
    .msg_data        (msg_data),
    .cfg_devgrp      (cfg_devgrp),
    .cfg_remap_off   (cfg_remap_off),
    .cfg_remap_sleep (cfg_remap_sleep),
    .res_state       (res_state)
);

// File: tb/test_pwrmsg_decoder.sv
`timescale 1ns/1ps
module test_pwrmsg_decoder;

    localparam int N = 28;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          msg_valid = 1'b0;
    logic [15:0]   msg_data = '0;
    logic [N*3-1:0] cfg_devgrp = '0;
    logic [N*3-1:0] cfg_kind = '0;
    logic [N*2-1:0] cfg_kind2 = '0;
    logic [N*4-1:0] cfg_remap_off = '0;
    logic [N*4-1:0] cfg_remap_sleep = '0;
    logic [N*4-1:0] res_state;
    logic [N-1:0]   res_enable;

    logic [3:0] exp_st [N];
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    pwrmsg_decoder i_pwrmsg_decoder (
        .clk             (clk),
        .rst_n           (rst_n),
        .msg_valid       (msg_valid),
        .msg_data        (msg_data),
        .cfg_devgrp      (cfg_devgrp),
        .cfg_kind        (cfg_kind),
        .cfg_kind2       (cfg_kind2),
        .cfg_remap_off   (cfg_remap_off),
        .cfg_remap_sleep (cfg_remap_sleep),
        .res_state       (res_state),
        .res_enable      (res_enable)
    );

    function automatic logic [15:0] mk_single(input logic [2:0] grp, input logic [7:0] id,
                                              input logic [3:0] st);
        return {grp, 1'b0, id, st};
    endfunction

    function automatic logic [15:0] mk_bcast(input logic [2:0] grp, input logic [2:0] rc,
                                             input logic [1:0] k2, input logic [2:0] k,
                                             input logic [3:0] st);
        return {grp, 1'b1, rc, k2, k, st};
    endfunction

    // Reference model built from R2..R6
    task automatic model_apply(input logic [15:0] m);
        for (int i = 0; i < N; i++) begin
            logic [2:0] cls;
            logic match;
            logic [3:0] s;
            cls = (i < 21) ? 3'b001 : ((i < 27) ? 3'b010 : 3'b100);
            if (m[12])
                match = ((cls & m[11:9]) != 0) && ((m[6:4] == 3'd7) || (m[6:4] == cfg_kind[i*3 +: 3]))
                        && (m[8:7] == cfg_kind2[i*2 +: 2]);
            else
                match = (32'(m[11:4]) == i + 1);
            if (match && ((cfg_devgrp[i*3 +: 3] & m[15:13]) != 0)) begin
                s = m[3:0];
                if (s == 4'h0) s = cfg_remap_off[i*4 +: 4];
                else if (s == 4'h8) s = cfg_remap_sleep[i*4 +: 4];
                exp_st[i] = s;
            end
        end
    endtask

    task automatic check_all(input string tag);
        int first;
        logic [3:0] a_st, e_st;
        logic a_en, e_en;
        first = -1;
        for (int i = 0; i < N; i++) begin
            e_en = (exp_st[i] == 4'hE) || (exp_st[i] == 4'hF);
            if (first < 0 && (res_state[i*4 +: 4] !== exp_st[i] || res_enable[i] !== e_en))
                first = i;
        end
        total++;
        if (first >= 0) begin
            bad++;
            a_st = res_state[first*4 +: 4];
            e_st = exp_st[first];
            a_en = res_enable[first];
            e_en = (e_st == 4'hE) || (e_st == 4'hF);
            $display("FAIL %s resource %0d state=%h/en=%b expected state=%h/en=%b",
                     tag, first + 1, a_st, a_en, e_st, e_en);
        end
    endtask

    task automatic send(input logic [15:0] m, input string tag);
        @(negedge clk);
        msg_data  = m;
        msg_valid = 1'b1;
        model_apply(m);
        @(negedge clk);
        msg_valid = 1'b0;
        msg_data  = 16'($urandom);
        check_all(tag);
    endtask

    task automatic rand_cfg();
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            cfg_devgrp[i*3 +: 3]      = 3'($urandom);
            cfg_kind[i*3 +: 3]        = 3'($urandom_range(0, 3));
            cfg_kind2[i*2 +: 2]       = 2'($urandom_range(0, 1));
            cfg_remap_off[i*4 +: 4]   = 4'($urandom);
            cfg_remap_sleep[i*4 +: 4] = 4'($urandom);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7741));
        for (int i = 0; i < N; i++) begin
            exp_st[i] = 4'h0;
            cfg_devgrp[i*3 +: 3]      = (i == 9) ? 3'b010 : 3'b001;
            cfg_kind[i*3 +: 3]        = (i < 10) ? 3'd1 : 3'd2;
            cfg_kind2[i*2 +: 2]       = 2'd0;
            cfg_remap_off[i*4 +: 4]   = 4'(i);
            cfg_remap_sleep[i*4 +: 4] = (i >= 21 && i < 27) ? 4'h3 : 4'h8;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        send(mk_single(3'b001, 8'd5, 4'hE), "R2 single active");
        send(mk_single(3'b101, 8'd28, 4'hF), "R2/R7 single warm reset");
        send(mk_single(3'b001, 8'd0, 4'hE), "R3 id zero");
        send(mk_single(3'b001, 8'd29, 4'hE), "R3 id 29");
        send(mk_single(3'b111, 8'd200, 4'hF), "R3 id 200");
        send(mk_single(3'b000, 8'd5, 4'h0), "R4 empty group");
        send(mk_single(3'b001, 8'd10, 4'hE), "R4 disjoint group");
        send(mk_single(3'b010, 8'd10, 4'hE), "R4 overlapping group");
        send(mk_bcast(3'b111, 3'b111, 2'd0, 3'd7, 4'hE), "R5/R7 broadcast all");
        send(mk_bcast(3'b001, 3'b010, 2'd0, 3'd7, 4'h8), "R5/R6 sleep reset-control class");
        send(mk_bcast(3'b001, 3'b001, 2'd0, 3'd7, 4'h0), "R5/R6 off providers");
        send(mk_bcast(3'b011, 3'b111, 2'd0, 3'd1, 4'hF), "R5 type filter");
        send(mk_bcast(3'b001, 3'b111, 2'd1, 3'd7, 4'h0), "R5 secondary type filter");
        send(mk_bcast(3'b001, 3'b000, 2'd0, 3'd7, 4'h0), "R5 empty class mask");
        send(mk_single(3'b001, 8'd3, 4'h8), "R6 sleep kept as sleep");
        send(mk_single(3'b001, 8'd4, 4'h5), "R6 other state stored");

        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            msg_data = 16'($urandom);
        end
        check_all("R8 idle hold");

        for (int n = 0; n < 400; n++) begin
            logic [15:0] m;
            logic [3:0] st;
            int kind;
            string tag;
            if (n % 50 == 0) rand_cfg();
            case ($urandom_range(0, 4))
                0: st = 4'h0;
                1: st = 4'h8;
                2: st = 4'hE;
                3: st = 4'hF;
                default: st = 4'($urandom);
            endcase
            kind = $urandom_range(0, 3);
            if (kind == 0) begin
                m = mk_bcast(3'($urandom), 3'($urandom), 2'($urandom_range(0, 1)),
                             3'($urandom_range(0, 7)), st);
                tag = "R5/R6 random broadcast";
            end else if (kind == 3) begin
                m = mk_single(3'($urandom), 8'($urandom), st);
                tag = (m[11:4] == 0 || m[11:4] > 28) ? "R3 random id" : "R2/R4 random single";
            end else begin
                m = mk_single(3'($urandom), 8'($urandom_range(1, 28)), st);
                tag = "R2/R6 random single";
            end
            send(m, tag);
            if (n % 37 == 0) begin
                repeat (2) @(negedge clk);
                check_all("R8 random idle");
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule